// File: doc/BRIEF.md
# Sixteen-Bit Carry-Select Adder with Increment Converters

This block adds two 16-bit operands and an incoming carry, producing a 16-bit sum and an outgoing carry. To shorten the carry path compared with a plain ripple chain, the operand bits are cut into five slices of 2, 2, 3, 4 and 5 bits, starting from the least significant end. The bottom slice is an ordinary ripple adder that takes the external carry. Each upper slice adds its bits once, assuming no incoming carry. An increment unit then forms the same result plus one, with the carry included, so the slice has both candidate answers ready before its real incoming carry arrives. The carry leaving each slice steers the choice in the slice above, and the choice made in the top slice gives the final carry.

The increment unit replaces the second ripple adder that a classic carry-select slice would need. It is one bit wider than its slice, so that the candidate carry is incremented together with the sum bits. A parameter decides whether the sum and carry leave through a register stage, which gives one cycle of latency and a reset to zero, or leave straight from the logic.

Top module: `csel_adder`

## Requirements
- R1: For every operand pair and incoming carry, {cout, sum} equals the 17-bit value a + b + cin.
- R2: With REG_OUT = 1, sum and cout show the result for the inputs present at one rising clock edge, from that edge until the next one; this one-cycle latency holds for every input pattern.
- R3: While rst_n is low (active-low), the registered sum and cout read as zero after each rising clock edge.
- R4: A carry that enters at the bottom and ripples through all five slices (a = 16'hFFFF, b = 16'h0000, cin = 1) gives sum = 16'h0000 and cout = 1.
- R5: A carry leaving one slice makes the next slice select its incremented candidate. Slice boundaries sit between bits 1/2, 3/4, 6/7 and 10/11. Operands that carry across exactly one boundary give the arithmetic result, for example 16'h0003 + 16'h0001 = 16'h0004.
- R6: cout is 1 exactly when a + b + cin is at least 65536, and is 0 otherwise.
- R7: The largest inputs (a = b = 16'hFFFF, cin = 1) give sum = 16'hFFFF and cout = 1.
- R8: Adding b = 0 with cin = 0 returns sum equal to a and cout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset that clears the output register |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Incoming carry |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Outgoing carry |

## Verification
The bench builds the adder with its default REG_OUT = 1, so the register stage, its reset value and its one-cycle latency are all exercised. With this setting every result is sampled one edge after it is applied. The directed cases put a carry across each of the four slice boundaries one at a time, and also drive a carry through all five slices at once. These cases cover both positions of every slice's select. The random operands then cover the mixed select patterns between those cases.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int NGRP = 5;
    localparam int GRP_W [NGRP] = '{2, 2, 3, 4, 5};

    function automatic int grp_lo(input int g);
        int acc;
        acc = 0;
        for (int k = 0; k < g; k++) begin
            acc += GRP_W[k];
        end
        return acc;
    endfunction

    localparam int WIDTH = grp_lo(NGRP);

endpackage

// File: rtl/csel_fa.sv
module csel_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
    end
endmodule

// File: rtl/csel_rca.sv
module csel_rca #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;
    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        csel_fa u_fa (
            .x (a[i]),
            .y (b[i]),
            .ci(c[i]),
            .s (s[i]),
            .co(c[i+1])
        );
    end

    assign co = c[W];
endmodule

// File: rtl/csel_inc.sv
module csel_inc #(
    parameter int W = 3
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] all_ones;

    assign all_ones[0] = 1'b1;
    for (genvar i = 1; i < W; i++) begin : g_and
        assign all_ones[i] = all_ones[i-1] & din[i-1];
    end

    for (genvar i = 0; i < W; i++) begin : g_flip
        assign dout[i] = din[i] ^ all_ones[i];
    end
endmodule

// File: rtl/csel_slice.sv
module csel_slice #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [W:0]   plus_one;

    csel_rca #(.W(W)) u_rca (
        .a (a),
        .b (b),
        .ci(1'b0),
        .s (s_zero),
        .co(c_zero)
    );

    csel_inc #(.W(W + 1)) u_inc (
        .din ({c_zero, s_zero}),
        .dout(plus_one)
    );

    always_comb begin
        if (sel) begin
            {co, s} = plus_one;
        end else begin
            {co, s} = {c_zero, s_zero};
        end
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [NGRP:0]    carry;
    logic [WIDTH-1:0] sum_c;

    assign carry[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        localparam int LO = grp_lo(g);
        localparam int GW = GRP_W[g];
        if (g == 0) begin : g_base
            csel_rca #(.W(GW)) u_base (
                .a (a[LO +: GW]),
                .b (b[LO +: GW]),
                .ci(carry[0]),
                .s (sum_c[LO +: GW]),
                .co(carry[1])
            );
        end else begin : g_sel
            csel_slice #(.W(GW)) u_slice (
                .a  (a[LO +: GW]),
                .b  (b[LO +: GW]),
                .sel(carry[g]),
                .s  (sum_c[LO +: GW]),
                .co (carry[g+1])
            );
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_c;
                cout <= carry[NGRP];
            end
        end
    end else begin : g_comb
        assign sum  = sum_c;
        assign cout = carry[NGRP];
    end
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk
    import csel_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    if (REG_OUT) begin : g_seq
        AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {16'b0, $past(cin)}))); // R1 R2
        AST_COUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (cout == (({1'b0, $past(a)} + {1'b0, $past(b)} + {16'b0, $past(cin)}) > 17'h0FFFF))); // R6
        AST_FULL_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(a) == 16'hFFFF && $past(b) == 16'h0000 && $past(cin))
            |-> (sum == 16'h0000 && cout)); // R4
        AST_MAX_OPS: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(a) == 16'hFFFF && $past(b) == 16'hFFFF && $past(cin))
            |-> (sum == 16'hFFFF && cout)); // R7
        AST_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(b) == 16'h0000 && !$past(cin))
            |-> (sum == $past(a) && !cout)); // R8
    end else begin : g_cmb
        AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            {cout, sum} == ({1'b0, a} + {1'b0, b} + {16'b0, cin})); // R1
        AST_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
            (b == 16'h0000 && !cin) |-> (sum == a && !cout)); // R8
        AST_MAX_OPS: assert property (@(posedge clk) disable iff (!rst_n)
            (a == 16'hFFFF && b == 16'hFFFF && cin) |-> (sum == 16'hFFFF && cout)); // R7
        AST_FULL_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
            (a == 16'hFFFF && b == 16'h0000 && cin) |-> (sum == 16'h0000 && cout)); // R4
    end
endmodule

bind csel_adder csel_adder_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_csel_adder.sv
module test_csel_adder;
    logic        clk;
    logic        rst_n;
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [15:0] sum;
    logic        cout;

    int n_checks;
    int n_fail;
    bit done;

    csel_adder #(.REG_OUT(1'b1)) i_csel_adder (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y,
                                            input logic c);
        return {1'b0, x} + {1'b0, y} + {16'b0, c};
    endfunction

    task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input string req, input logic [15:0] x, input logic [15:0] y,
                         input logic c);
        logic [16:0] exp;
        @(negedge clk);
        a = x; b = y; cin = c;
        exp = ref_add(x, y, c);
        @(negedge clk);
        check(req, {cout, sum}, exp);
        check({req, " R6 carry"}, {16'b0, cout}, {16'b0, (exp >= 17'h10000)});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n = 1'b0;
        a = 16'h1234; b = 16'h4321; cin = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 reset", {cout, sum}, 17'h0);
        a = 16'hFFFF; b = 16'hFFFF;
        @(negedge clk);
        check("R3 reset hold", {cout, sum}, 17'h0);
        rst_n = 1'b1;

        apply("R4 full ripple", 16'hFFFF, 16'h0000, 1'b1);
        apply("R7 max", 16'hFFFF, 16'hFFFF, 1'b1);
        apply("R8 identity", 16'hBEEF, 16'h0000, 1'b0);
        apply("R8 identity zero", 16'h0000, 16'h0000, 1'b0);
        apply("R5 boundary 1/2", 16'h0003, 16'h0001, 1'b0);
        apply("R5 boundary 3/4", 16'h000C, 16'h0004, 1'b0);
        apply("R5 boundary 6/7", 16'h0040, 16'h0040, 1'b0);
        apply("R5 boundary 10/11", 16'h0400, 16'h0400, 1'b0);
        apply("R5 cin into boundary", 16'h0003, 16'h0000, 1'b1);
        apply("R6 carry edge low", 16'h8000, 16'h7FFF, 1'b0);
        apply("R6 carry edge high", 16'h8000, 16'h7FFF, 1'b1);

        // R2: back-to-back vectors, each result one edge after its inputs
        begin
            logic [16:0] exp_prev;
            @(negedge clk);
            a = 16'h1111; b = 16'h2222; cin = 1'b0;
            exp_prev = ref_add(16'h1111, 16'h2222, 1'b0);
            @(negedge clk);
            a = 16'hF0F0; b = 16'h0F10; cin = 1'b1;
            check("R2 latency", {cout, sum}, exp_prev);
            exp_prev = ref_add(16'hF0F0, 16'h0F10, 1'b1);
            @(negedge clk);
            check("R2 latency next", {cout, sum}, exp_prev);
        end

        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'($urandom());
            y = 16'($urandom());
            apply("R1 random", x, y, 1'($urandom()));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule